// File: doc/BRIEF.md
# Glitch-Free Gated Clock Fanout

This block selects one of two reference clocks and fans the result out to five outputs split into two banks: outputs 0 and 1 in the first bank, outputs 2 to 4 in the second. Every output carries the same gated clock.

Each output is modelled by three signals: a logic level, a drive flag, and a weak pull-low flag. The drive flag at 0 stands for high impedance. A single enable input is resynchronised on the falling edge of the selected clock. Because of this, outputs begin and stop toggling only while the clock is low, so no runt pulse ever reaches them.

When the enable turns off, the outputs are first driven low. On the following rising clock edge they are released to high impedance.

The reference inputs are handled as follows:
- The differential reference is read as high only when the true leg is high and the complement leg is low. An undriven pair is treated as both legs low, which gives a low output.
- The oscillator reference is inverted.

An active-low asynchronous reset floats all outputs and clears the enable synchroniser.

Top module: `fanout_clock_gate`

## Requirements
- R1: With `selOsc` = 0 the selected clock is `clkDiffP & ~clkDiffN`. True-high/complement-low gives a high output. True-low/complement-high gives a low output. Both legs low, which is the open case, gives a low output.
- R2: With `selOsc` = 1 the selected clock is the inverse of `clkOsc`. A static 0 gives a high output and a static 1 gives a low output. `clkDiffP` and `clkDiffN` have no effect in this mode.
- R3: All five outputs always carry identical level, drive and weak-pull values, across both banks.
- R4: While the synchronised enable is on, every output is driven (`outDrive` = 1) and its level equals the selected clock.
- R5: After `outEnable` rises, the outputs are undriven, at level 0 and with `outWeakLow` = 1. This holds until the second falling edge of the selected clock. From that edge onward they are driven and follow the clock.
- R6: After `outEnable` falls, the outputs keep following the clock until the second falling edge. From that edge they are driven low. From the next rising edge they are undriven, with `outWeakLow` = 0, and they stay that way while the enable stays low.
- R7: An output whose drive flag is 0 always shows level 0, so a high level only ever appears while the output is driven.
- R8: If `outEnable` rises while the selected clock is static, the outputs hold a fixed value (undriven, weak low, level 0) and do not toggle.
- R9: While `rstN` = 0 all outputs are undriven, at level 0 and with `outWeakLow` = 0. After `rstN` is released the synchroniser starts empty, so two falling edges are again needed before the outputs are driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rstN | input | 1 | Asynchronous active-low reset |
| clkDiffP | input | 1 | Differential reference, true leg |
| clkDiffN | input | 1 | Differential reference, complement leg |
| clkOsc | input | 1 | Oscillator reference (inverting path) |
| selOsc | input | 1 | Reference select: 0 = differential, 1 = oscillator |
| outEnable | input | 1 | Shared output enable, asynchronous to the clocks |
| clkOut | output | 5 | Output logic levels |
| outDrive | output | 5 | Output drive flags (0 = high impedance) |
| outWeakLow | output | 5 | Weak pull-low active on the output |

## Verification
Consider a synchroniser stage that is stuck or skipped. The enable latency would shift by a falling edge, so the outputs would start or stop one clock early or late. This shows within two cycles of any enable change.

Consider a release register clocked on the wrong edge. The output would float while still high, or the driven-low interval would vanish. This appears in the first half-cycle after the second falling edge.

Consider a decode or inversion error in the input mux. It shows at once as a wrong static level on all five outputs.

A bank mismatch shows on the very next sample.

// File: rtl/fanout_gate_pkg.sv
package fanout_gate_pkg;

  // Strobes from the enable control to the output datapath
  typedef struct packed {
    logic gateOpen;  // synchronised enable: outputs follow the clock
    logic driveOn;   // outputs actively driven
    logic weakOn;    // weak pull-low applied while undriven
  } gateStrobe_t;

endpackage

// File: rtl/fanout_gate_ctrl.sv
module fanout_gate_ctrl
  import fanout_gate_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        selClk,
  input  logic        rstN,
  input  logic        enableIn,
  output gateStrobe_t strobe
);

  logic syncOut;
  logic releaseReg;

  // Enable resynchroniser on the falling edge of the selected clock
  generate
    if (SYNC_STAGES > 1) begin : gChain
      logic [SYNC_STAGES-1:0] syncChain;
      always_ff @(negedge selClk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], enableIn};
      end
      assign syncOut = syncChain[SYNC_STAGES-1];
    end else begin : gSingle
      logic syncFlop;
      always_ff @(negedge selClk or negedge rstN) begin
        if (!rstN) syncFlop <= 1'b0;
        else       syncFlop <= enableIn;
      end
      assign syncOut = syncFlop;
    end
  endgenerate

  // Drive release follows the synchronised enable on the rising edge,
  // leaving the outputs low for half a cycle before they float
  always_ff @(posedge selClk or negedge rstN) begin
    if (!rstN) releaseReg <= 1'b0;
    else       releaseReg <= syncOut;
  end

  always_comb begin
    strobe.gateOpen = syncOut;
    strobe.driveOn  = syncOut | releaseReg;
    strobe.weakOn   = rstN & enableIn & ~(syncOut | releaseReg);
  end

endmodule

// File: rtl/fanout_gate_datapath.sv
module fanout_gate_datapath
  import fanout_gate_pkg::*;
#(
  parameter int NUM_OUT      = 5,
  parameter int BANK_A_COUNT = 2
) (
  input  logic               clkDiffP,
  input  logic               clkDiffN,
  input  logic               clkOsc,
  input  logic               selOsc,
  input  gateStrobe_t        strobe,
  output logic               selClk,
  output logic [NUM_OUT-1:0] clkOut,
  output logic [NUM_OUT-1:0] outDrive,
  output logic [NUM_OUT-1:0] outWeakLow
);

  localparam int BANK_B_COUNT = NUM_OUT - BANK_A_COUNT;

  logic diffLevel;
  logic oscLevel;
  logic gatedLevel;

  always_comb begin
    diffLevel  = clkDiffP & ~clkDiffN;
    oscLevel   = ~clkOsc;
    selClk     = selOsc ? oscLevel : diffLevel;
    gatedLevel = selClk & strobe.gateOpen;
  end

  generate
    for (genvar g = 0; g < NUM_OUT; g++) begin : gOut
      if (g < BANK_A_COUNT) begin : gBankA
        assign clkOut[g]     = gatedLevel;
        assign outDrive[g]   = strobe.driveOn;
        assign outWeakLow[g] = strobe.weakOn;
      end else if (g - BANK_A_COUNT < BANK_B_COUNT) begin : gBankB
        assign clkOut[g]     = gatedLevel;
        assign outDrive[g]   = strobe.driveOn;
        assign outWeakLow[g] = strobe.weakOn;
      end
    end
  endgenerate

endmodule

// File: rtl/fanout_clock_gate.sv
module fanout_clock_gate
  import fanout_gate_pkg::*;
#(
  parameter int NUM_OUT      = 5,
  parameter int BANK_A_COUNT = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic               rstN,
  input  logic               clkDiffP,
  input  logic               clkDiffN,
  input  logic               clkOsc,
  input  logic               selOsc,
  input  logic               outEnable,
  output logic [NUM_OUT-1:0] clkOut,
  output logic [NUM_OUT-1:0] outDrive,
  output logic [NUM_OUT-1:0] outWeakLow
);

  gateStrobe_t strobe;
  logic        selClk;

  fanout_gate_datapath #(
    .NUM_OUT(NUM_OUT),
    .BANK_A_COUNT(BANK_A_COUNT)
  ) i_datapath (
    .clkDiffP(clkDiffP),
    .clkDiffN(clkDiffN),
    .clkOsc(clkOsc),
    .selOsc(selOsc),
    .strobe(strobe),
    .selClk(selClk),
    .clkOut(clkOut),
    .outDrive(outDrive),
    .outWeakLow(outWeakLow)
  );

  fanout_gate_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) i_ctrl (
    .selClk(selClk),
    .rstN(rstN),
    .enableIn(outEnable),
    .strobe(strobe)
  );

endmodule

// File: rtl/fanout_gate_checker.sv
module fanout_gate_checker #(
  parameter int NUM_OUT = 5
) (
  input logic               selClk,
  input logic               rstN,
  input logic [NUM_OUT-1:0] clkOut,
  input logic [NUM_OUT-1:0] outDrive,
  input logic [NUM_OUT-1:0] outWeakLow
);

  // R3: both banks carry the same values
  a_r3_banks_agree: assert property (@(posedge selClk) disable iff (!rstN)
    (clkOut == '0 || clkOut == '1) && (outDrive == '0 || outDrive == '1) &&
    (outWeakLow == '0 || outWeakLow == '1));

  // R7: high level only while driven (sampled with the clock high)
  a_r7_float_is_low: assert property (@(negedge selClk) disable iff (!rstN)
    !outDrive[0] |-> !clkOut[0]);

  // R5: weak pull-low never overlaps active drive
  a_r5_weak_excludes_drive: assert property (@(negedge selClk) disable iff (!rstN)
    outWeakLow[0] |-> !outDrive[0]);

  // R6: an output is released only after being held low
  a_r6_release_after_low: assert property (@(posedge selClk) disable iff (!rstN)
    $fell(outDrive[0]) |-> !$past(clkOut[0]));

endmodule

bind fanout_clock_gate fanout_gate_checker #(.NUM_OUT(NUM_OUT)) i_checker (
  .selClk(selClk),
  .rstN(rstN),
  .clkOut(clkOut),
  .outDrive(outDrive),
  .outWeakLow(outWeakLow)
);

// File: tb/test_fanout_clock_gate.sv
module test_fanout_clock_gate;

  localparam int CLK_PERIOD = 20;
  localparam int QTR        = CLK_PERIOD / 4;
  localparam int NUM_OUT    = 5;

  // Static decode vectors: {selOsc, clkDiffP, clkDiffN, clkOsc, expected level}
  localparam logic [4:0] DECODE_VEC [7] = '{
    5'b0_10_1_1, 5'b0_01_0_0, 5'b0_00_1_0,
    5'b1_00_0_1, 5'b1_11_1_0, 5'b1_10_0_1, 5'b1_01_1_0
  };

  logic rstN, clkDiffP, clkDiffN, clkOsc, selOsc, outEnable;
  logic [NUM_OUT-1:0] clkOut, outDrive, outWeakLow;
  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 0;

  fanout_clock_gate i_fanout_clock_gate (
    .rstN(rstN), .clkDiffP(clkDiffP), .clkDiffN(clkDiffN), .clkOsc(clkOsc),
    .selOsc(selOsc), .outEnable(outEnable),
    .clkOut(clkOut), .outDrive(outDrive), .outWeakLow(outWeakLow)
  );

  task automatic checkOut(string req, logic expLvl, logic expDrv, logic expWeak);
    logic [NUM_OUT-1:0] eL, eD, eW;
    eL = {NUM_OUT{expLvl}};
    eD = {NUM_OUT{expDrv}};
    eW = {NUM_OUT{expWeak}};
    checkCount++;
    if (clkOut !== eL || outDrive !== eD || outWeakLow !== eW) begin
      failCount++;
      $display("FAIL %s: level/drive/weak actual %b/%b/%b expected %b/%b/%b",
               req, clkOut, outDrive, outWeakLow, eL, eD, eW);
    end
  endtask

  // Move the selected clock to a level, centred in a half period
  task automatic clkLvl(logic lvl);
    #(QTR);
    if (!selOsc) begin
      clkDiffP = lvl;
      clkDiffN = ~lvl;
    end else begin
      clkOsc = ~lvl;
    end
    #(QTR);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    rstN = 0; selOsc = 0; clkDiffP = 0; clkDiffN = 1; clkOsc = 1; outEnable = 0;
    #(CLK_PERIOD);
    checkOut("R9 reset", 0, 0, 0);
    outEnable = 1;
    #(QTR);
    checkOut("R9 reset with enable", 0, 0, 0);
    outEnable = 0;
    rstN = 1;
    #(QTR);
    checkOut("R6 idle disabled", 0, 0, 0);

    // Enable rise latency on the differential path
    outEnable = 1;
    #(QTR);
    checkOut("R5 weak after enable", 0, 0, 1);
    clkLvl(1); checkOut("R5 rise before fall1", 0, 0, 1);
    clkLvl(0); checkOut("R5 after fall1", 0, 0, 1);
    clkLvl(1); checkOut("R5 rise before fall2", 0, 0, 1);
    clkLvl(0); checkOut("R5 at fall2 driven", 0, 1, 0);
    for (int i = 0; i < 3; i++) begin
      clkLvl(1); checkOut("R4 follow high", 1, 1, 0);
      clkLvl(0); checkOut("R4 follow low", 0, 1, 0);
    end

    // Enable fall sequence
    clkLvl(1);
    outEnable = 0;
    #1;
    checkOut("R6 still following", 1, 1, 0);
    clkLvl(0); checkOut("R6 fall1", 0, 1, 0);
    clkLvl(1); checkOut("R6 high before fall2", 1, 1, 0);
    clkLvl(0); checkOut("R6 driven low at fall2", 0, 1, 0);
    clkLvl(1); checkOut("R6 released at rise", 0, 0, 0);
    clkLvl(0); checkOut("R6 stays floating", 0, 0, 0);
    clkLvl(1); checkOut("R7 floating while clock high", 0, 0, 0);

    // Enable with a static clock (high)
    outEnable = 1;
    for (int i = 0; i < 10; i++) begin
      #(QTR);
      checkOut("R8 static clock no toggle", 0, 0, 1);
    end

    // Reset, then oscillator path latency with cleared synchroniser
    rstN = 0;
    #(QTR);
    checkOut("R9 reset clears", 0, 0, 0);
    selOsc = 1; clkOsc = 1; clkDiffP = 1; clkDiffN = 0;
    #(QTR);
    rstN = 1;
    #(QTR);
    checkOut("R9 weak after reset release", 0, 0, 1);
    clkLvl(1); checkOut("R2 osc rise before fall1", 0, 0, 1);
    clkLvl(0); checkOut("R9 still weak after fall1", 0, 0, 1);
    clkLvl(1); checkOut("R2 osc rise before fall2", 0, 0, 1);
    clkLvl(0); checkOut("R2 osc driven at fall2", 0, 1, 0);
    clkLvl(1); checkOut("R2 osc follow high", 1, 1, 0);
    if (clkOsc !== 1'b0) begin
      failCount++;
      $display("FAIL R2: bench osc level actual %b expected 0", clkOsc);
    end

    // Static decode table while enabled
    for (int v = 0; v < 7; v++) begin
      {selOsc, clkDiffP, clkDiffN, clkOsc} = DECODE_VEC[v][4:1];
      #(2 * QTR);
      checkOut(DECODE_VEC[v][4] ? "R2 osc decode" : "R1 diff decode",
               DECODE_VEC[v][0], 1, 0);
    end

    // Asynchronous reset while running with a high output
    selOsc = 0; clkDiffP = 1; clkDiffN = 0;
    #(2 * QTR);
    checkOut("R3 all outputs high", 1, 1, 0);
    rstN = 0;
    #1;
    checkOut("R9 async reset mid-run", 0, 0, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

endmodule